// File: doc/BRIEF.md
# Two-stage SCL prescaler

This block turns a fast system clock into the timing grid that an I2C master's bus engine follows. Two programmable dividers sit in a chain. The first divides the clock by (A+1). The second divides the first stage's pulses by (B+1). A fixed 22-step counter then spans one SCL period. The overall SCL rate is therefore the clock rate over 22·(A+1)·(B+1). The largest ratio is 22·4·64 with the default 2-bit A and 6-bit B fields.

The 22-step counter drives the SCL level and marks four quarter points. SCL is pulled low for steps 0 to 10 and released for steps 11 to 21. A one-cycle tick, tagged with a quarter code, tells the bus engine when to change or sample SDA. Software picks A and B. The divisors it writes are taken only at an SCL period boundary.

The block samples the real line level. If SCL is released but still seen low during the high half, the whole chain freezes, which lets a slave stretch the clock. Dropping the enable clears every counter and releases SCL.

Top module: `sclPrescaler`

## Requirements
- R1: While reset is active or `enable` is low, `sclOut` is 1, `tick` is 0 and `quarter` is 0. This holds from the first clock edge after `enable` falls, and divisor inputs have no effect.
- R2: With no stretching, the 22-step counter advances once every (A+1)·(B+1) clock cycles. One SCL period is therefore 22·(A+1)·(B+1) cycles, for any A in 0..3 and B in 0..63.
- R3: Ticks arrive at step 0 (`quarter`=0, SCL falls), step 5 (`quarter`=1), step 11 (`quarter`=2, SCL rises) and step 16 (`quarter`=3). They come in the order 0,1,2,3,0 and are spaced 5,6,5,6 steps apart: step 0 to 5, 5 to 11, 11 to 16, 16 to 0.
- R4: `sclOut` is 0 during steps 0..10 and 1 during steps 11..21. At a tick, `sclOut` equals bit 1 of `quarter`.
- R5: A divisor change while enabled has no effect until the next step-0 boundary. From there the new ratio applies.
- R6: When `sclOut` is 1 but `sclIn` is 0, every counter holds. The tick at step 16 is delayed by exactly the number of held cycles. A low `sclIn` during the low half has no effect.
- R7: After `enable` rises, counting restarts from step 0 with the divisors present at that time. The first tick, `quarter`=1, comes 5·(A+1)·(B+1) cycles after the first enabled edge.
- R8: `tick` is high for exactly one clock cycle per quarter point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the prescaler; low clears all counters |
| divA | input | 2 | First-stage divisor A (divide by A+1) |
| divB | input | 6 | Second-stage divisor B (divide by B+1) |
| sclIn | input | 1 | Sampled SCL line level, used to detect stretching |
| tick | output | 1 | One-cycle pulse at each quarter point |
| quarter | output | 2 | Code of the latest quarter point (0..3) |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |

## Verification
The bench uses the default parameters: a 22-step base, a 2-bit A and a 6-bit B. These let the run set both extreme ratios. A=0, B=0 makes every stage terminal on every cycle, so each step is one clock. A=3, B=63 fills both counters, so each step is 256 cycles and one period is 5632 cycles. The intermediate ratios 6 and 3 exercise a divisor change across a period boundary. A 40-cycle stretch shows the hold adding exactly its own length to one quarter gap.

// File: rtl/sclPresPkg.sv
package sclPresPkg;
  // control -> phase datapath
  typedef struct packed {
    logic step;   // advance the 22-step counter this cycle
  } presStrobe_t;

  // phase datapath -> control
  typedef struct packed {
    logic wrap;   // SCL period boundary taken this cycle
    logic hold;   // line stretched by a slave, freeze everything
  } phaseFb_t;
endpackage

// File: rtl/sclPresCtl.sv
module sclPresCtl
  import sclPresPkg::*;
#(
  parameter int A_W = 2,
  parameter int B_W = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [A_W-1:0] divA,
  input  logic [B_W-1:0] divB,
  input  phaseFb_t       fb,
  output presStrobe_t    strb
);
  logic [A_W-1:0] aLat, aCnt;
  logic [B_W-1:0] bLat, bCnt;
  logic aTerm, bTerm;

  assign aTerm     = (aCnt == aLat);
  assign bTerm     = (bCnt == bLat);
  assign strb.step = enable && !fb.hold && aTerm && bTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aCnt <= '0;
      bCnt <= '0;
      aLat <= '0;
      bLat <= '0;
    end else if (!enable) begin
      aCnt <= '0;
      bCnt <= '0;
      aLat <= divA;
      bLat <= divB;
    end else if (!fb.hold) begin
      if (aTerm) begin
        aCnt <= '0;
        bCnt <= bTerm ? '0 : bCnt + 1'b1;
      end else begin
        aCnt <= aCnt + 1'b1;
      end
      // new divisors only at the period boundary
      if (fb.wrap) begin
        aLat <= divA;
        bLat <= divB;
      end
    end
  end
endmodule

// File: rtl/sclPresPhase.sv
module sclPresPhase
  import sclPresPkg::*;
#(
  parameter int BASE_COUNT = 22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sclIn,
  input  presStrobe_t strb,
  output phaseFb_t    fb,
  output logic        tick,
  output logic [1:0]  quarter,
  output logic        sclOut
);
  localparam int CW     = $clog2(BASE_COUNT);
  localparam int LOW_N  = BASE_COUNT / 2;
  localparam int Q1_PT  = LOW_N / 2;
  localparam int Q3_PT  = LOW_N + (BASE_COUNT - LOW_N) / 2;
  localparam int LAST   = BASE_COUNT - 1;

  logic [CW-1:0] phase, phaseNxt;
  logic          running, highHalf;
  logic          hitQ;
  logic [1:0]    hitCode;

  assign highHalf = (phase >= CW'(LOW_N));
  assign sclOut   = !running || highHalf;
  assign fb.hold  = running && highHalf && !sclIn;
  assign fb.wrap  = strb.step && (phase == CW'(LAST));
  assign phaseNxt = (phase == CW'(LAST)) ? '0 : phase + 1'b1;

  always_comb begin
    hitQ    = 1'b1;
    hitCode = 2'd0;
    if (phaseNxt == CW'(0))          hitCode = 2'd0;
    else if (phaseNxt == CW'(Q1_PT)) hitCode = 2'd1;
    else if (phaseNxt == CW'(LOW_N)) hitCode = 2'd2;
    else if (phaseNxt == CW'(Q3_PT)) hitCode = 2'd3;
    else                             hitQ    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      running <= 1'b0;
      tick    <= 1'b0;
      quarter <= 2'd0;
    end else begin
      running <= enable;
      if (!enable) begin
        phase   <= '0;
        tick    <= 1'b0;
        quarter <= 2'd0;
      end else begin
        tick <= 1'b0;
        if (strb.step) begin
          phase <= phaseNxt;
          if (hitQ) begin
            tick    <= 1'b1;
            quarter <= hitCode;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sclPrescaler.sv
module sclPrescaler
  import sclPresPkg::*;
#(
  parameter int BASE_COUNT = 22,
  parameter int A_W        = 2,
  parameter int B_W        = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [A_W-1:0] divA,
  input  logic [B_W-1:0] divB,
  input  logic           sclIn,
  output logic           tick,
  output logic [1:0]     quarter,
  output logic           sclOut
);
  presStrobe_t strb;
  phaseFb_t    fb;

  sclPresCtl #(.A_W(A_W), .B_W(B_W)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .divA(divA), .divB(divB), .fb(fb), .strb(strb)
  );

  sclPresPhase #(.BASE_COUNT(BASE_COUNT)) u_phase (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
    .strb(strb), .fb(fb), .tick(tick), .quarter(quarter), .sclOut(sclOut)
  );
endmodule

// File: rtl/sclPrescalerChk.sv
module sclPrescalerChk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       sclIn,
  input logic       tick,
  input logic [1:0] quarter,
  input logic       sclOut
);
  logic [1:0] lastQ;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) lastQ <= 2'd0;
    else if (tick)        lastQ <= quarter;
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !tick && quarter == 2'd0));

  p_quarter_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (quarter == 2'(lastQ + 2'd1)));

  p_scl_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (sclOut == quarter[1]));

  p_stretch_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sclOut && !sclIn) |=> !tick);

  p_tick_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

bind sclPrescaler sclPrescalerChk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
  .tick(tick), .quarter(quarter), .sclOut(sclOut)
);

// File: tb/sclPrescaler_tb.sv
module sclPrescaler_tb;
  logic       clk = 1'b0;
  logic       rstN, enable, stretch;
  logic [1:0] divA;
  logic [5:0] divB;
  logic       sclIn, tick, sclOut;
  logic [1:0] quarter;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int refCyc  = 0;
  bit done    = 0;
  bit prevTick = 0;

  typedef struct {
    int    gap;
    int    q;
    string tag;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sclIn = sclOut & ~stretch;

  sclPrescaler u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divA(divA), .divB(divB),
    .sclIn(sclIn), .tick(tick), .quarter(quarter), .sclOut(sclOut)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic pushTick(int gap, int q, string tag);
    item_t it;
    it.gap = gap;
    it.q   = q;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // quarter gaps in steps: to q1 5, to q2 6, to q3 5, to q0 6
  task automatic pushRun(int p, int firstQ, int n, string tag);
    for (int i = 0; i < n; i++) begin
      int q;
      q = (firstQ + i) % 4;
      pushTick(((q % 2) == 1 ? 5 : 6) * p, q, tag);
    end
  endtask

  task automatic waitDrain();
    do begin
      @(negedge clk);
      #1;
    end while (expQ.size() != 0);
  endtask

  task automatic checkIdle(string tag);
    check(sclOut == 1'b1, tag, "idle sclOut", int'(sclOut), 1);
    check(tick == 1'b0, tag, "idle tick", int'(tick), 0);
    check(quarter == 2'd0, tag, "idle quarter", int'(quarter), 0);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rstN) begin
      refCyc = cyc + 1;
    end else begin
      if (tick) begin
        check(!prevTick, "R8", "tick width", 2, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected tick quarter", int'(quarter), -1);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(cyc - refCyc == it.gap, it.tag, "tick gap", cyc - refCyc, it.gap);
          check(int'(quarter) == it.q, it.tag, "quarter code", int'(quarter), it.q);
          check(sclOut == (it.q >= 2), "R4", "scl level at tick",
                int'(sclOut), (it.q >= 2) ? 1 : 0);
        end
        refCyc = cyc;
      end
      if (!enable) refCyc = cyc + 1;
    end
    prevTick = tick;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; stretch = 1'b0; divA = 2'd0; divB = 6'd0;
    repeat (2) @(posedge clk);
    #1 enable = 1'b1;
    @(posedge clk);
    #1 checkIdle("R1");
    @(posedge clk);
    #1 rstN = 1'b1;

    // ratio 1: every stage terminal each cycle
    pushRun(1, 1, 8, "R3");
    waitDrain();

    // disable, divisors changed while idle are ignored
    @(posedge clk);
    #1 enable = 1'b0;
    repeat (2) @(negedge clk);
    checkIdle("R1");
    divA = 2'd1; divB = 6'd2;
    repeat (40) @(negedge clk);
    checkIdle("R1");

    // restart with ratio 6
    @(posedge clk);
    #1 enable = 1'b1;
    pushRun(6, 1, 8, "R7");
    waitDrain();

    // divisor change mid-period: takes effect at step 0
    pushRun(6, 1, 1, "R2");
    waitDrain();
    @(posedge clk);
    #1 divA = 2'd2; divB = 6'd0;
    pushRun(6, 2, 3, "R5");
    pushRun(3, 1, 4, "R5");
    waitDrain();

    // stretch asserted in low half: no effect there
    @(posedge clk);
    #1 stretch = 1'b1;
    pushRun(3, 1, 2, "R6");
    waitDrain();
    repeat (20) @(posedge clk);
    #1;
    check(sclOut == 1'b1, "R6", "released during stretch", int'(sclOut), 1);
    check(sclIn == 1'b0, "R6", "line low during stretch", int'(sclIn), 0);
    repeat (20) @(posedge clk);
    #1 stretch = 1'b0;
    pushTick(5 * 3 + 40, 3, "R6");
    pushTick(6 * 3, 0, "R6");
    waitDrain();

    // largest ratio 4*64
    @(posedge clk);
    #1 enable = 1'b0; divA = 2'd3; divB = 6'd63;
    repeat (2) @(posedge clk);
    #1 enable = 1'b1;
    pushRun(256, 1, 4, "R2");
    waitDrain();

    @(posedge clk);
    #1 enable = 1'b0;
    repeat (2) @(negedge clk);
    checkIdle("R1");
    check(expQ.size() == 0, "R3", "leftover expected ticks", expQ.size(), 0);
    finishRun();
  end
endmodule